// File: doc/BRIEF.md
# Receive FIFO with Level Interrupt

This block buffers words handed over by a serial receiver until a host collects them. It stores up to sixteen 16-bit words in first-in, first-out order. It publishes its fill count as a plain binary number. The receiver offers a word with a one-cycle valid strobe, and the host takes the oldest word with a one-cycle pop strobe. The popped word then appears on a registered output.

Two sticky flags tell the host what has happened. The level flag rises on the clock edge where the fill count changes to a value equal to a programmable threshold. The overflow flag rises when a word arrives with no room left for it. Each flag stays set until the host pulses its own clear input. An enable input decides whether the level flag reaches the interrupt request line. A run control holds the FIFO empty, with both pointers at zero, for as long as it is low.

Top module: `rx_level_fifo`

## Requirements
- R1: `fill_count` is the number of stored words in plain binary, from 0 (empty) to 16 (full). It changes on the clock edge that samples an accepted push or pop.
- R2: Words leave in the order they were accepted. A pop that the FIFO accepts places the oldest word on `pop_data` at the same edge.
- R3: While `run` is 0, the pointers and `fill_count` are held at zero, and pushes and pops are ignored. After `run` returns to 1, the first word pushed is the first word popped.
- R4: `level_flag` sets on the edge where `fill_count` changes to a value equal to `level`. Changing `level` to the current count does not by itself set the flag.
- R5: `level_flag` stays set until a cycle with `level_clr` at 1. If a set event and `level_clr` fall in the same cycle, the flag is set.
- R6: `irq` is 1 exactly when `level_flag` is 1 and `irq_en` is 1.
- R7: A push while the count is 16 and no pop is accepted in the same cycle is discarded. The stored words stay unchanged, and `ovf_flag` sets.
- R8: `ovf_flag` stays set until a cycle with `ovf_clr` at 1. A set event wins over a clear in the same cycle.
- R9: A push together with an accepted pop leaves the count unchanged. This holds at 16 as well, where both operations are performed and no overflow is flagged.
- R10: A pop while the count is 0 is ignored, and `pop_data` keeps its last value.
- R11: `rst_n` low clears, asynchronously, the stored count, the pointers, both flags and `pop_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Receiver offers a word this cycle |
| push_data | input | 16 | Word from the receiver |
| pop | input | 1 | Host takes the oldest word this cycle |
| pop_data | output | 16 | Last word popped (registered) |
| run | input | 1 | 0 holds the FIFO empty, 1 lets it operate |
| level | input | 5 | Fill count that raises the level flag |
| irq_en | input | 1 | Lets the level flag drive `irq` |
| level_clr | input | 1 | One-cycle pulse that clears the level flag |
| ovf_clr | input | 1 | One-cycle pulse that clears the overflow flag |
| fill_count | output | 5 | Stored word count |
| level_flag | output | 1 | Sticky level-match flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The count, `pop_data` and both flags are registered, so the bench expects each of them one edge after the cycle that drove the stimulus. `irq` is combinational on top of the flag, so it moves in that same cycle. The bench drives each cycle at the falling edge, lets one rising edge pass, and compares every output with its model at the next falling edge. The asynchronous reset is the one exception: it is checked one time unit after `rst_n` falls, with no clock edge in between.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_BOTH = 2'b11
    } fifo_op_t;
endpackage

// File: rtl/rxq_mem.sv
module rxq_mem #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot_d [DEPTH];
    logic [DATA_W-1:0] slot_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_d[i] = slot_q[i];
            if (wr_en && wr_ptr == PTR_W'(i)) slot_d[i] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
        end
    end

    assign rd_data = slot_q[rd_ptr];

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> slot_q[$past(wr_ptr)] == $past(wr_data));
endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             push_valid,
    input  logic             pop,
    input  logic [CNT_W-1:0] level,
    output logic             wr_en,
    output logic             rd_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             ovf_evt,
    output logic             hit_evt
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    fifo_op_t   op;
    logic       do_push, do_pop;

    always_comb begin
        do_pop  = run && pop && (st_q.cnt != '0);
        do_push = run && push_valid && ((st_q.cnt != FULL) || do_pop);
        ovf_evt = run && push_valid && (st_q.cnt == FULL) && !do_pop;
        op      = fifo_op_t'({do_pop, do_push});
        st_d    = st_q;
        case (op)
            OP_PUSH: begin
                st_d.wptr = st_q.wptr + PTR_W'(1);
                st_d.cnt  = st_q.cnt + CNT_W'(1);
            end
            OP_POP: begin
                st_d.rptr = st_q.rptr + PTR_W'(1);
                st_d.cnt  = st_q.cnt - CNT_W'(1);
            end
            OP_BOTH: begin
                st_d.wptr = st_q.wptr + PTR_W'(1);
                st_d.rptr = st_q.rptr + PTR_W'(1);
            end
            default: ;
        endcase
        if (!run) st_d = '0;
        hit_evt = (st_d.cnt == level) && (st_d.cnt != st_q.cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en  = do_push;
    assign rd_en  = do_pop;
    assign wr_ptr = st_q.wptr;
    assign rd_ptr = st_q.rptr;
    assign count  = st_q.cnt;

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL);
    assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.cnt == '0) && (st_q.wptr == '0) && (st_q.rptr == '0));
    assert_full_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && push_valid && !pop && st_q.cnt == FULL) |=> $stable(st_q));
    assert_pushpop_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && push_valid && pop && st_q.cnt != '0) |=> $stable(st_q.cnt));
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_evt,
    input  logic ovf_evt,
    input  logic level_clr,
    input  logic ovf_clr,
    output logic level_flag,
    output logic ovf_flag
);
    typedef struct packed {
        logic lvl;
        logic ovf;
    } flag_state_t;

    flag_state_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (level_clr) fl_d.lvl = 1'b0;
        if (hit_evt)   fl_d.lvl = 1'b1;
        if (ovf_clr)   fl_d.ovf = 1'b0;
        if (ovf_evt)   fl_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign level_flag = fl_q.lvl;
    assign ovf_flag   = fl_q.ovf;

    assert_hit_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_evt |=> fl_q.lvl);
    assert_level_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.lvl && !level_clr) |=> fl_q.lvl);
    assert_ovf_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> fl_q.ovf);
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.ovf && !ovf_clr) |=> fl_q.ovf);
endmodule

// File: rtl/rx_level_fifo.sv
module rx_level_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    input  logic              run,
    input  logic [CNT_W-1:0]  level,
    input  logic              irq_en,
    input  logic              level_clr,
    input  logic              ovf_clr,
    output logic [CNT_W-1:0]  fill_count,
    output logic              level_flag,
    output logic              ovf_flag,
    output logic              irq
);
    logic              wr_en, rd_en, ovf_evt, hit_evt;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [DATA_W-1:0] head_word;
    logic [DATA_W-1:0] data_d, data_q;

    rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .run(run), .push_valid(push_valid),
        .pop(pop), .level(level), .wr_en(wr_en), .rd_en(rd_en),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(fill_count),
        .ovf_evt(ovf_evt), .hit_evt(hit_evt)
    );

    rxq_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr),
        .wr_data(push_data), .rd_ptr(rd_ptr), .rd_data(head_word)
    );

    rxq_flags u_flags (
        .clk(clk), .rst_n(rst_n), .hit_evt(hit_evt), .ovf_evt(ovf_evt),
        .level_clr(level_clr), .ovf_clr(ovf_clr),
        .level_flag(level_flag), .ovf_flag(ovf_flag)
    );

    always_comb begin
        data_d = data_q;
        if (rd_en) data_d = head_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign pop_data = data_q;
    assign irq      = level_flag & irq_en;

    assert_empty_pop_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && fill_count == '0) |=> $stable(pop_data));
    assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (level_flag && irq_en));
endmodule

// File: tb/sim_rx_level_fifo.sv
module sim_rx_level_fifo;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_valid, pop, run, irq_en, level_clr, ovf_clr;
    logic [15:0] push_data;
    logic [4:0]  level;
    logic [15:0] pop_data;
    logic [4:0]  fill_count;
    logic        level_flag, ovf_flag, irq;

    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    int          mq[$];
    int          m_cnt, m_data;
    bit          m_if, m_ovf;

    always #(CLK_P / 2) clk = ~clk;

    rx_level_fifo u0 (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .pop(pop), .pop_data(pop_data), .run(run), .level(level), .irq_en(irq_en),
        .level_clr(level_clr), .ovf_clr(ovf_clr), .fill_count(fill_count),
        .level_flag(level_flag), .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1 count", fill_count, m_cnt);
        chk("R2 pop_data", pop_data, m_data);
        chk("R4 level_flag", level_flag, m_if);
        chk("R6 irq", irq, m_if & irq_en);
        chk("R7 ovf_flag", ovf_flag, m_ovf);
    endtask

    // One clock: drive at the falling edge, update the model, compare at the next falling edge.
    task automatic tick(input bit p, input int d, input bit po, input bit ci, input bit co);
        bit dpop, dpush, ovf_e, hit;
        int old;
        push_valid = p; push_data = d[15:0]; pop = po; level_clr = ci; ovf_clr = co;
        old   = m_cnt;
        dpop  = run && po && m_cnt != 0;
        dpush = run && p && (m_cnt != 16 || dpop);
        ovf_e = run && p && m_cnt == 16 && !dpop;
        if (dpop) m_data = mq.pop_front();
        if (dpush) mq.push_back(d & 16'hFFFF);
        if (!run) mq.delete();
        m_cnt = mq.size();
        hit   = (m_cnt == int'(level)) && (m_cnt != old);
        if (ci) m_if = 0;
        if (hit) m_if = 1;
        if (co) m_ovf = 0;
        if (ovf_e) m_ovf = 1;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic model_reset();
        mq.delete(); m_cnt = 0; m_data = 0; m_if = 0; m_ovf = 0;
    endtask

    initial begin
        rst_n = 0; run = 0; level = 0; irq_en = 0;
        push_valid = 0; pop = 0; level_clr = 0; ovf_clr = 0; push_data = 0;
        model_reset();
        repeat (2) @(negedge clk);
        compare_all(); // R11 reset state
        rst_n = 1;
        run = 1;
        tick(0, 0, 0, 0, 0);

        // Sweep every threshold: fill to full, overflow, drain.
        for (int lv = 0; lv <= 16; lv++) begin
            level = 5'(lv); irq_en = lv[0];
            run = 0; tick(1, 16'hDEAD, 1, 0, 0);   // R3: ignored while held
            chk("R3 held count", fill_count, 0);
            tick(0, 0, 0, 1, 1);
            run = 1;
            for (int i = 0; i < 16; i++) tick(1, lv * 256 + i, 0, 0, 0);
            chk("R4 flag after passing level", level_flag, (lv >= 1) ? 1 : 0);
            tick(1, 16'hBEEF, 0, 0, 0);            // R7: overflow, word dropped
            chk("R7 overflow set", ovf_flag, 1);
            chk("R7 count stays full", fill_count, 16);
            tick(0, 0, 0, 0, 0);
            chk("R8 overflow sticky", ovf_flag, 1);
            tick(0, 0, 0, 1, 1);
            chk("R5 level cleared", level_flag, 0);
            chk("R8 overflow cleared", ovf_flag, 0);
            for (int i = 0; i < 16; i++) begin
                tick(0, 0, 1, 0, 0);
                chk("R2 order", pop_data, lv * 256 + i);
            end
            tick(0, 0, 1, 0, 0);                   // R10: pop while empty
            chk("R10 empty pop holds", pop_data, lv * 256 + 15);
        end

        // R5 set wins over a clear in the same cycle.
        level = 3; irq_en = 1;
        tick(1, 1, 0, 0, 0); tick(1, 2, 0, 1, 1);
        tick(1, 3, 0, 1, 0);
        chk("R5 set wins", level_flag, 1);
        chk("R6 irq enabled", irq, 1);
        irq_en = 0; tick(0, 0, 0, 0, 0);
        chk("R6 irq masked", irq, 0);
        // R4 level change alone does not set.
        tick(0, 0, 0, 1, 0);
        level = 5'(m_cnt); tick(0, 0, 0, 0, 0); tick(0, 0, 0, 0, 0);
        chk("R4 no set on level write", level_flag, 0);
        // R9 push with pop in the middle.
        level = 20;
        tick(1, 77, 1, 0, 0);
        chk("R9 count unchanged", fill_count, 3);
        for (int i = 0; i < 13; i++) tick(1, 100 + i, 0, 0, 0);
        tick(1, 555, 1, 0, 0);                     // R9 at full
        chk("R9 full push+pop no overflow", ovf_flag, 0);
        chk("R9 full count", fill_count, 16);
        // R8 set wins over clear.
        tick(1, 9, 0, 0, 1);
        chk("R8 set wins", ovf_flag, 1);
        // R3 restart order after hold.
        run = 0; tick(0, 0, 0, 0, 0);
        run = 1; tick(1, 4242, 0, 0, 0); tick(1, 4343, 0, 0, 0);
        tick(0, 0, 1, 0, 0);
        chk("R3 first after restart", pop_data, 4242);
        // R11 asynchronous reset mid-cycle.
        tick(1, 11, 0, 1, 0);
        #(CLK_P / 4) rst_n = 0;
        #1;
        model_reset();
        chk("R11 count cleared", fill_count, 0);
        chk("R11 data cleared", pop_data, 0);
        chk("R11 overflow cleared", ovf_flag, 0);
        @(negedge clk); rst_n = 1;
        tick(0, 0, 0, 0, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule